// File: doc/BRIEF.md
# Peak Clip-Excess Generator with Feedback Window

This block sits between an envelope-magnitude stage and a peak-smoothing window in a crest factor reduction path. Each valid input sample is an envelope magnitude that already carries the vectoring-rotator gain (about 1.64676). It is compared against a run-time threshold given in that same scaled domain, so no gain correction is needed on the magnitude side. The positive part of the difference is the raw excess.

A short recursive filter runs over the block's own recent clamped outputs. Its result is subtracted from the raw excess, and anything below zero is forced to zero. The clamped value feeds the downstream smoothing window. When peaks sit close together, the energy already removed for earlier peaks is credited to later ones, so a cluster is not clipped twice. The filter length is half of the downstream window: 32 taps for a 64-sample window.

A select input picks between a triangular and a rounded coefficient shape per sample. Debug outputs expose the raw excess, the pre-clamp difference and the feedback filter result.

Top module: `cfr_clip_excess`

## Requirements
- R1: All data ports are 13-bit two's complement, Q2.11 format (value = code / 2048). The raw excess is mag − thr when that difference is positive and zero otherwise. It saturates at 4095.
- R2: The magnitude is compared with the threshold directly, with no gain applied. Any magnitude at or below the threshold yields zero raw excess and zero output.
- R3: The pre-clamp value `dbg_pre` is raw excess − feedback. The output `out_excess` equals `dbg_pre` when that is positive and is 0 otherwise.
- R4: The feedback value is floor(Σ c[k]·y[n−1−k] / 1024) for k = 0..31, saturated to 4095. Here y[n−1] is the most recent earlier output. The history advances only on valid samples.
- R5: With `win_sel` = 0 the taps are triangular: c[k] = floor(1024·(32−k)/64).
- R6: With `win_sel` = 1 the taps are rounded: c[k] = floor(1024·(1024−k²)/2048). `win_sel` is sampled together with each sample's `in_valid`, so the shape can change from one sample to the next.
- R7: `out_valid` follows `in_valid` exactly two clock cycles later.
- R8: A cycle with `sclr` high clears the pipeline, the outputs and the feedback history. After a clear, the next sample sees zero feedback.
- R9: While `out_valid` is low, all data outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sclr | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_mag | input | 13 | Gain-scaled envelope magnitude, Q2.11 |
| in_thr | input | 13 | Gain-scaled clip threshold, Q2.11 |
| win_sel | input | 1 | 0 triangular taps, 1 rounded taps |
| out_valid | output | 1 | Output sample qualifier |
| out_excess | output | 13 | Clamped excess to the smoothing window |
| dbg_raw | output | 13 | Raw excess before feedback |
| dbg_pre | output | 13 | Raw excess minus feedback, before clamp |
| dbg_fb | output | 13 | Feedback filter result |

## Verification
A wrong history entry or a wrong tap does not show at once. It appears in `dbg_fb` at the next valid sample that follows a non-zero output. From there it spreads into `out_excess` and into every later sample for up to 32 valid samples. The bench therefore runs long clusters of back-to-back peaks, gapped streams and per-sample shape switching, and compares every output word each cycle. A latency or qualifier error shows at the very next sample as a mismatch of `out_valid` or of held data.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  // Triangular tap k of an n-tap feedback window, cf fractional bits
  function automatic int tri_coef(int n, int cf, int k);
    return ((n - k) << cf) / (2 * n);
  endfunction

  // Rounded (parabolic) tap k of an n-tap feedback window
  function automatic int rnd_coef(int n, int cf, int k);
    return ((n * n - k * k) << cf) / (2 * n * n);
  endfunction

endpackage

// File: rtl/cfr_excess_stage.sv
module cfr_excess_stage #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         sclr,
  input  logic         in_valid,
  input  logic [W-1:0] in_mag,
  input  logic [W-1:0] in_thr,
  input  logic         win_sel,
  output logic         s1_valid,
  output logic [W-1:0] s1_raw,
  output logic         s1_sel
);
  localparam logic [W:0]   MAXW = {2'b00, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

  logic signed [W:0] diff;
  logic [W-1:0]      raw_c;

  always_comb begin
    diff = $signed({in_mag[W-1], in_mag}) - $signed({in_thr[W-1], in_thr});
    if (diff[W] || diff == '0)
      raw_c = '0;
    else if (diff > $signed(MAXW))
      raw_c = MAXP;
    else
      raw_c = diff[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (sclr) begin
      s1_valid <= 1'b0;
      s1_raw   <= '0;
      s1_sel   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_raw <= raw_c;
        s1_sel <= win_sel;
      end
    end
  end
endmodule

// File: rtl/cfr_fb_fir.sv
module cfr_fb_fir #(
  parameter int W  = 13,
  parameter int N  = 32,
  parameter int CF = 10
) (
  input  logic         clk,
  input  logic         sclr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         sel,
  output logic [W-1:0] fb
);
  localparam int ACCW = W + CF + $clog2(N) + 1;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]    hist [N];
  logic [ACCW-1:0] prod [N];
  logic [ACCW-1:0] acc;
  logic [ACCW-1:0] scaled;

  always_ff @(posedge clk) begin
    if (sclr) begin
      for (int i = 0; i < N; i++) hist[i] <= '0;
    end else if (push) begin
      hist[0] <= push_data;
      for (int i = 1; i < N; i++) hist[i] <= hist[i-1];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_tap
    localparam logic [CF:0] CT = (CF+1)'(cfr_pkg::tri_coef(N, CF, k));
    localparam logic [CF:0] CR = (CF+1)'(cfr_pkg::rnd_coef(N, CF, k));
    logic [CF:0] coef;
    assign coef    = sel ? CR : CT;
    assign prod[k] = ACCW'(hist[k]) * ACCW'(coef);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + prod[i];
    scaled = acc >> CF;
    fb = (scaled > ACCW'(MAXP)) ? MAXP : scaled[W-1:0];
  end
endmodule

// File: rtl/cfr_clamp_stage.sv
module cfr_clamp_stage #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         sclr,
  input  logic         s1_valid,
  input  logic [W-1:0] s1_raw,
  input  logic [W-1:0] fb,
  output logic [W-1:0] y_next,
  output logic         out_valid,
  output logic [W-1:0] out_excess,
  output logic [W-1:0] dbg_raw,
  output logic [W-1:0] dbg_pre,
  output logic [W-1:0] dbg_fb
);
  logic [W-1:0] pre_c;

  always_comb begin
    pre_c  = s1_raw - fb;
    y_next = pre_c[W-1] ? '0 : pre_c;
  end

  always_ff @(posedge clk) begin
    if (sclr) begin
      out_valid  <= 1'b0;
      out_excess <= '0;
      dbg_raw    <= '0;
      dbg_pre    <= '0;
      dbg_fb     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_excess <= y_next;
        dbg_raw    <= s1_raw;
        dbg_pre    <= pre_c;
        dbg_fb     <= fb;
      end
    end
  end
endmodule

// File: rtl/cfr_clip_excess.sv
module cfr_clip_excess #(
  parameter int W      = 13,
  parameter int WIN    = 64,
  parameter int CF     = 10
) (
  input  logic         clk,
  input  logic         sclr,
  input  logic         in_valid,
  input  logic [W-1:0] in_mag,
  input  logic [W-1:0] in_thr,
  input  logic         win_sel,
  output logic         out_valid,
  output logic [W-1:0] out_excess,
  output logic [W-1:0] dbg_raw,
  output logic [W-1:0] dbg_pre,
  output logic [W-1:0] dbg_fb
);
  localparam int FB_TAPS = WIN / 2;

  logic         s1_valid;
  logic [W-1:0] s1_raw;
  logic         s1_sel;
  logic [W-1:0] fb;
  logic [W-1:0] y_next;

  cfr_excess_stage #(.W(W)) u_exc (
    .clk(clk), .sclr(sclr), .in_valid(in_valid), .in_mag(in_mag),
    .in_thr(in_thr), .win_sel(win_sel),
    .s1_valid(s1_valid), .s1_raw(s1_raw), .s1_sel(s1_sel)
  );

  cfr_fb_fir #(.W(W), .N(FB_TAPS), .CF(CF)) u_fir (
    .clk(clk), .sclr(sclr), .push(s1_valid), .push_data(y_next),
    .sel(s1_sel), .fb(fb)
  );

  cfr_clamp_stage #(.W(W)) u_clamp (
    .clk(clk), .sclr(sclr), .s1_valid(s1_valid), .s1_raw(s1_raw), .fb(fb),
    .y_next(y_next), .out_valid(out_valid), .out_excess(out_excess),
    .dbg_raw(dbg_raw), .dbg_pre(dbg_pre), .dbg_fb(dbg_fb)
  );
endmodule

// File: rtl/cfr_clip_excess_chk.sv
module cfr_clip_excess_chk #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         sclr,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_excess,
  input logic [W-1:0] dbg_raw,
  input logic [W-1:0] dbg_pre,
  input logic [W-1:0] dbg_fb
);
  logic [1:0] since_clr;

  always_ff @(posedge clk) begin
    if (sclr) since_clr <= 2'd0;
    else if (since_clr != 2'd3) since_clr <= since_clr + 2'd1;
  end

  // R7: two-cycle qualifier latency once two clean edges have passed
  a_r7_latency: assert property (@(posedge clk) disable iff (sclr)
    (since_clr >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R8: a clear empties the outputs on the next edge
  a_r8_clear: assert property (@(posedge clk)
    sclr |=> (!out_valid && out_excess == '0 && dbg_fb == '0));

  // R3: the output never exceeds the raw excess
  a_r3_out_le_raw: assert property (@(posedge clk) disable iff (sclr)
    out_valid |-> ($signed(out_excess) <= $signed(dbg_raw)));

  // R3: a positive difference passes through unchanged
  a_r3_pos_pass: assert property (@(posedge clk) disable iff (sclr)
    (out_valid && !dbg_pre[W-1] && dbg_pre != '0) |-> (out_excess == dbg_pre));

  // R2: zero raw excess gives zero output
  a_r2_zero_raw: assert property (@(posedge clk) disable iff (sclr)
    (out_valid && dbg_raw == '0) |-> (out_excess == '0));

  // R9: data holds while no valid sample leaves
  a_r9_hold: assert property (@(posedge clk) disable iff (sclr)
    (!out_valid && since_clr >= 2'd1) |-> $stable(out_excess));
endmodule

bind cfr_clip_excess cfr_clip_excess_chk #(.W(W)) u_chk (
  .clk(clk), .sclr(sclr), .in_valid(in_valid), .out_valid(out_valid),
  .out_excess(out_excess), .dbg_raw(dbg_raw), .dbg_pre(dbg_pre), .dbg_fb(dbg_fb)
);

// File: tb/cfr_clip_excess_tb.sv
module cfr_clip_excess_tb;
  localparam int W = 13;
  localparam int N = 32;

  logic clk = 1'b0;
  logic sclr = 1'b1, in_valid = 1'b0, win_sel = 1'b0;
  logic [W-1:0] in_mag = '0, in_thr = '0;
  logic out_valid;
  logic [W-1:0] out_excess, dbg_raw, dbg_pre, dbg_fb;

  always #10 clk = ~clk;

  cfr_clip_excess u_dut (
    .clk(clk), .sclr(sclr), .in_valid(in_valid), .in_mag(in_mag),
    .in_thr(in_thr), .win_sel(win_sel), .out_valid(out_valid),
    .out_excess(out_excess), .dbg_raw(dbg_raw), .dbg_pre(dbg_pre), .dbg_fb(dbg_fb)
  );

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;

  // model state
  int s1_v, s1_raw, s1_sel;
  int o_v, o_y, o_raw, o_pre, o_fb, o_sel;
  int hist [N];

  function automatic int coef(int sel, int k);
    if (sel == 0) return (1024 * (32 - k)) / 64;
    return (1024 * (1024 - k * k)) / 2048;
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    s1_v = 0; s1_raw = 0; s1_sel = 0;
    o_v = 0; o_y = 0; o_raw = 0; o_pre = 0; o_fb = 0; o_sel = 0;
    for (int i = 0; i < N; i++) hist[i] = 0;
  endtask

  task automatic step(int clr, int v, int mag, int thr, int sel);
    longint acc;
    int fbv, pre, d;
    @(negedge clk);
    if (armed) begin
      check("R7 valid", int'(out_valid), o_v);
      if (o_v != 0) begin
        check("R1 raw", sx(dbg_raw), o_raw);
        check(o_sel ? "R6 fb rounded" : "R5 fb triangular", sx(dbg_fb), o_fb);
        check("R3 pre", sx(dbg_pre), o_pre);
        check("R3 out", sx(out_excess), o_y);
      end else begin
        check("R9 hold out", sx(out_excess), o_y);
        check("R9 hold fb", sx(dbg_fb), o_fb);
      end
    end
    sclr = clr[0]; in_valid = v[0]; in_mag = W'(mag); in_thr = W'(thr); win_sel = sel[0];
    if (clr != 0) begin
      model_clear();
    end else begin
      o_v = s1_v;
      if (s1_v != 0) begin
        acc = 0;
        for (int k = 0; k < N; k++) acc += longint'(coef(s1_sel, k)) * hist[k];
        acc = acc >>> 10;
        fbv = (acc > 4095) ? 4095 : int'(acc);
        pre = s1_raw - fbv;
        o_raw = s1_raw; o_fb = fbv; o_pre = pre; o_y = (pre > 0) ? pre : 0;
        o_sel = s1_sel;
        for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = o_y;
      end
      s1_v = v;
      if (v != 0) begin
        d = mag - thr;
        s1_raw = (d <= 0) ? 0 : ((d > 4095) ? 4095 : d);
        s1_sel = sel;
      end
    end
  endtask

  initial begin
    int lf;
    model_clear();
    repeat (3) @(negedge clk);
    armed = 1;
    // R8 reset state
    step(0, 0, 0, 0, 0);
    check("R8 reset out", sx(out_excess), 0);
    // R1/R2 sweep, triangular, continuous
    for (int m = 0; m < 4096; m += 61) step(0, 1, m, 1500, 0);
    // R6 sweep, rounded
    for (int m = 0; m < 4096; m += 53) step(0, 1, m, 1200, 1);
    // R2 below or at threshold gives zero
    for (int m = 0; m <= 900; m += 100) step(0, 1, m, 900, 0);
    // R4 peak cluster with feedback, then long gap then more
    for (int i = 0; i < 40; i++) step(0, 1, 3000, 200, i % 2);
    for (int i = 0; i < 10; i++) step(0, 0, 4000, 0, 1);
    for (int i = 0; i < 20; i++) step(0, 1, 2500 - 50 * i, 300, 0);
    // R1 saturation of raw excess, signed inputs
    for (int i = 0; i < 8; i++) step(0, 1, 4095, -4096, 1);
    // R8 clear mid-run, then feedback starts from zero
    step(1, 1, 3000, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R8 cleared valid", int'(out_valid), 0);
    check("R8 cleared out", sx(out_excess), 0);
    for (int i = 0; i < 6; i++) step(0, 1, 2000, 100, 0);
    // gapped pseudo-random stream with switching shape (R5 R6 R9)
    lf = 32'h1ACE;
    for (int i = 0; i < 600; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      step(0, (lf >> 3) & 1, (lf & 8191) - 4096, ((lf >> 5) & 2047) - 300, (lf >> 9) & 1);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule